// File: doc/BRIEF.md
# Prioritized Two-Line Interrupt Controller

This block gathers a parameterized set of level-sensitive interrupt sources (a multiple of 32, at most 128) and presents them to a processor as two request lines: a normal request and a fast request. Each source carries its own configuration word that picks the line it drives and a 6-bit urgency value. A source takes part in arbitration when its input (or a software-forced copy of it) is high, it is unmasked, and it passes a global urgency threshold. The most urgent source on each line wins.

Each line has its own winner latch. The latch loads a new result whenever its line is idle. Once a winner is latched, the line stays high and the reported source number and urgency stay frozen until software writes the matching acknowledge bit in the control register. A handler can copy the reported urgency into the threshold register to allow nested interrupts. Priority 0 always passes the threshold. All access goes through a plain 32-bit register port with single-cycle writes and combinational reads.

Top module: `prio_intc`

## Requirements
- R1: After reset both request lines are low, the active registers (0x40 normal, 0x44 fast) read 0x7F, the urgency registers (0x60, 0x64) read 0, every bank mask reads all ones, and the threshold register (0x68) reads 0xFF.
- R2: Bank b occupies 0x80+32*b. Offset 0x04 reads the mask (1 = masked). Writing ones to offset 0x08 unmasks those sources and writing ones to offset 0x0C masks them. Zero bits written to either port change nothing.
- R3: Writing ones to bank offset 0x10 forces those sources pending. The forced bits read back at 0x10 and stay set until ones are written to offset 0x14. A forced bit is ORed with the input before masking. Offset 0x00 reads the raw inputs only.
- R4: The configuration word of source i is at 0x100+4*i. Bits 7:2 hold its urgency and bit 0 routes it to the fast line (1) or the normal line (0).
- R5: Among the qualifying sources on a line, the smallest urgency value wins. Ties go to the lowest source number.
- R6: A source whose urgency is numerically at or above the threshold does not qualify, except that urgency 0 always qualifies. A threshold of 0xFF masks nothing.
- R7: The active registers report the latched winner in bits 6:0 and the urgency registers report its urgency. With no winner, the request line is low, the active register reads 0x7F and the urgency register reads 0.
- R8: An idle line captures the current winner at the next clock edge. A latched winner and its urgency stay unchanged until a write to the control register at 0x48 with bit 0 (normal) or bit 1 (fast) set, which re-runs arbitration at that edge.
- R9: Writing bit 1 of the configuration register at 0x10 resets all controller state. Bit 0 of the status register at 0x14 reads 0 in the cycle after that write and 1 afterwards.
- R10: Bank offsets 0x18 and 0x1C read the unmasked pending sources routed to the normal and fast line respectively. The threshold does not apply to these views.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| src_i | input | N_SRC | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Normal request line |
| fiq_o | output | 1 | Fast request line |

## Verification
A corrupted mask or forced-pending bit shows on the next read of that bank and changes which winner is latched at the next acknowledge. A wrong winner latch shows as a bad source number, a bad urgency, or a request line that is high or low when it should not be. Because the latch holds until the acknowledge, such an error stays visible until that write. The bench compares every acknowledge against a model of the qualify-and-pick rule. It also drives directed cases where a better source arrives while a winner is held, where two sources tie, and where the threshold meets urgency 0.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

    localparam int ADDR_W   = 10;
    localparam int BANK_W   = 32;
    localparam int PRIO_W   = 6;
    localparam int ID_W     = 7;

    localparam logic [ADDR_W-1:0] A_CFG       = 10'h010;
    localparam logic [ADDR_W-1:0] A_STATUS    = 10'h014;
    localparam logic [ADDR_W-1:0] A_ACT_IRQ   = 10'h040;
    localparam logic [ADDR_W-1:0] A_ACT_FIQ   = 10'h044;
    localparam logic [ADDR_W-1:0] A_CTRL      = 10'h048;
    localparam logic [ADDR_W-1:0] A_PRIO_IRQ  = 10'h060;
    localparam logic [ADDR_W-1:0] A_PRIO_FIQ  = 10'h064;
    localparam logic [ADDR_W-1:0] A_THRESH    = 10'h068;

    typedef enum logic [2:0] {
        BR_RAW   = 3'd0,
        BR_MASK  = 3'd1,
        BR_UNMSK = 3'd2,
        BR_DOMSK = 3'd3,
        BR_FORCE = 3'd4,
        BR_UNFRC = 3'd5,
        BR_PNORM = 3'd6,
        BR_PFAST = 3'd7
    } bank_reg_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              fast;
    } lvl_t;

    typedef struct packed {
        logic              valid;
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } win_t;

    localparam win_t WIN_NONE = '{valid: 1'b0, id: 7'h7F, prio: 6'd0};

    function automatic logic passes_thr(input logic [PRIO_W-1:0] p, input logic [7:0] thr);
        return (p == '0) || ({2'b00, p} < thr);
    endfunction

endpackage

// File: rtl/prio_intc_bank.sv
module prio_intc_bank
    import prio_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  bank_reg_e         reg_sel,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] raw_i,
    input  logic [BANK_W-1:0] fast_i,
    output logic [BANK_W-1:0] pend_norm_o,
    output logic [BANK_W-1:0] pend_fast_o,
    output logic [BANK_W-1:0] rdata_o
);

    logic [BANK_W-1:0] mask_q;
    logic [BANK_W-1:0] force_q;
    logic [BANK_W-1:0] live;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '1;
            force_q <= '0;
        end else if (wr_en) begin
            case (reg_sel)
                BR_UNMSK: mask_q  <= mask_q & ~wdata;
                BR_DOMSK: mask_q  <= mask_q | wdata;
                BR_FORCE: force_q <= force_q | wdata;
                BR_UNFRC: force_q <= force_q & ~wdata;
                default: ;
            endcase
        end
    end

    assign live        = (raw_i | force_q) & ~mask_q;
    assign pend_norm_o = live & ~fast_i;
    assign pend_fast_o = live & fast_i;

    always_comb begin
        case (reg_sel)
            BR_RAW:   rdata_o = raw_i;
            BR_MASK:  rdata_o = mask_q;
            BR_FORCE: rdata_o = force_q;
            BR_PNORM: rdata_o = pend_norm_o;
            BR_PFAST: rdata_o = pend_fast_o;
            default:  rdata_o = '0;
        endcase
    end

    // R2: written ones land in the mask, zeros leave it alone
    a_r2_mask_set: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == BR_DOMSK) |=> ((mask_q & $past(wdata)) == $past(wdata)));
    a_r2_mask_clr: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_sel == BR_UNMSK) |=> ((mask_q & $past(wdata)) == '0));
    a_r2_mask_keep: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (reg_sel == BR_UNMSK || reg_sel == BR_DOMSK)) |=> $stable(mask_q));
    // R3: forced bits persist until the clear port is written
    a_r3_force_keep: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (reg_sel == BR_FORCE || reg_sel == BR_UNFRC)) |=> $stable(force_q));

endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
    import prio_intc_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic [N_SRC-1:0]             req_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
    output win_t                         win_o
);

    always_comb begin
        win_o = WIN_NONE;
        for (int i = 0; i < N_SRC; i++) begin
            if (req_i[i] && (!win_o.valid || prio_i[i] < win_o.prio)) begin
                win_o.valid = 1'b1;
                win_o.id    = ID_W'(i);
                win_o.prio  = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/prio_intc_latch.sv
module prio_intc_latch
    import prio_intc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rearm_i,
    input  win_t arb_i,
    output win_t win_o
);

    always_ff @(posedge clk) begin
        if (rst)
            win_o <= WIN_NONE;
        else if (!win_o.valid || rearm_i)
            win_o <= arb_i;
    end

    // R8: a held winner does not move without an acknowledge
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (win_o.valid && !rearm_i) |=> $stable(win_o));
    // R8: an idle line picks up a pending winner at the next edge
    a_r8_idle_take: assert property (@(posedge clk) disable iff (rst)
        (!win_o.valid && arb_i.valid) |=> win_o.valid);
    // R7: with no winner the reported number is the empty code
    a_r7_empty_id: assert property (@(posedge clk) disable iff (rst)
        !win_o.valid |-> (win_o.id == 7'h7F));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [N_SRC-1:0]  src_i,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam int N_BANK = N_SRC / BANK_W;
    localparam int SRC_W  = $clog2(N_SRC);

    logic srst_q;
    logic rst_int;
    logic [7:0] thr_q;
    lvl_t [N_SRC-1:0] lvl_q;
    logic [N_SRC-1:0] fast_vec, pend_norm, pend_fast, req_norm, req_fast;
    logic [N_SRC-1:0][PRIO_W-1:0] prio_vec;
    logic [N_BANK-1:0][31:0] bank_rd;
    logic [N_BANK-1:0] bank_wr;
    logic [7:0] lidx;
    logic lvl_hit, bank_hit;
    win_t arb_norm, arb_fast, win_norm, win_fast;
    logic rearm_norm, rearm_fast;

    assign rst_int  = rst | srst_q;
    assign lidx     = reg_addr[9:2] - 8'd64;
    assign lvl_hit  = (reg_addr[9:8] != 2'b00) && ({1'b0, lidx} < 9'(N_SRC));
    assign bank_hit = (reg_addr[9:7] == 3'b001) && ({1'b0, reg_addr[6:5]} < 3'(N_BANK));

    always_ff @(posedge clk) begin
        if (rst)
            srst_q <= 1'b0;
        else
            srst_q <= reg_wr && reg_addr == A_CFG && reg_wdata[1];
    end

    always_ff @(posedge clk) begin
        if (rst_int)
            thr_q <= 8'hFF;
        else if (reg_wr && reg_addr == A_THRESH)
            thr_q <= reg_wdata[7:0];
    end

    assign rearm_norm = reg_wr && reg_addr == A_CTRL && reg_wdata[0];
    assign rearm_fast = reg_wr && reg_addr == A_CTRL && reg_wdata[1];

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            always_ff @(posedge clk) begin
                if (rst_int)
                    lvl_q[i] <= '0;
                else if (reg_wr && lvl_hit && lidx == 8'(i))
                    lvl_q[i] <= '{prio: reg_wdata[7:2], fast: reg_wdata[0]};
            end
            assign fast_vec[i] = lvl_q[i].fast;
            assign prio_vec[i] = lvl_q[i].prio;
            assign req_norm[i] = pend_norm[i] && passes_thr(lvl_q[i].prio, thr_q);
            assign req_fast[i] = pend_fast[i] && passes_thr(lvl_q[i].prio, thr_q);
        end

        for (genvar b = 0; b < N_BANK; b++) begin : g_bank
            assign bank_wr[b] = reg_wr && bank_hit && reg_addr[6:5] == 2'(b);
            prio_intc_bank u_bank (
                .clk         (clk),
                .rst         (rst_int),
                .wr_en       (bank_wr[b]),
                .reg_sel     (bank_reg_e'(reg_addr[4:2])),
                .wdata       (reg_wdata),
                .raw_i       (src_i[b*BANK_W +: BANK_W]),
                .fast_i      (fast_vec[b*BANK_W +: BANK_W]),
                .pend_norm_o (pend_norm[b*BANK_W +: BANK_W]),
                .pend_fast_o (pend_fast[b*BANK_W +: BANK_W]),
                .rdata_o     (bank_rd[b])
            );
        end
    endgenerate

    prio_intc_arb #(.N_SRC(N_SRC)) u_arb_norm (.req_i(req_norm), .prio_i(prio_vec), .win_o(arb_norm));
    prio_intc_arb #(.N_SRC(N_SRC)) u_arb_fast (.req_i(req_fast), .prio_i(prio_vec), .win_o(arb_fast));

    prio_intc_latch u_lat_norm (.clk(clk), .rst(rst_int), .rearm_i(rearm_norm), .arb_i(arb_norm), .win_o(win_norm));
    prio_intc_latch u_lat_fast (.clk(clk), .rst(rst_int), .rearm_i(rearm_fast), .arb_i(arb_fast), .win_o(win_fast));

    assign irq_o = win_norm.valid;
    assign fiq_o = win_fast.valid;

    always_comb begin
        reg_rdata = '0;
        if (lvl_hit) begin
            reg_rdata[7:2] = lvl_q[lidx[SRC_W-1:0]].prio;
            reg_rdata[0]   = lvl_q[lidx[SRC_W-1:0]].fast;
        end else if (bank_hit) begin
            reg_rdata = bank_rd[reg_addr[5+$clog2(N_BANK > 1 ? N_BANK : 2)-1:5]];
        end else begin
            case (reg_addr)
                A_STATUS:   reg_rdata[0]      = ~srst_q;
                A_ACT_IRQ:  reg_rdata[6:0]    = win_norm.id;
                A_ACT_FIQ:  reg_rdata[6:0]    = win_fast.id;
                A_PRIO_IRQ: reg_rdata[5:0]    = win_norm.prio;
                A_PRIO_FIQ: reg_rdata[5:0]    = win_fast.prio;
                A_THRESH:   reg_rdata[7:0]    = thr_q;
                default: ;
            endcase
        end
    end

    // R5/R6: a winner offered to a latch must itself qualify on its line
    a_r6_norm_qual: assert property (@(posedge clk) disable iff (rst_int)
        arb_norm.valid |-> req_norm[arb_norm.id[SRC_W-1:0]]);
    a_r6_fast_qual: assert property (@(posedge clk) disable iff (rst_int)
        arb_fast.valid |-> req_fast[arb_fast.id[SRC_W-1:0]]);
    // R9: a soft reset write drops the done flag for one cycle
    a_r9_srst: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_CFG && reg_wdata[1]) |=> srst_q);
    a_r9_srst_end: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> !srst_q);

endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
    localparam int N = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [9:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] src_i = '0;
    logic irq_o, fiq_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [5:0]   m_prio [N];
    logic         m_fast [N];
    logic [N-1:0] m_mask, m_sw;
    logic [7:0]   m_thr;

    always #2 clk = ~clk;

    prio_intc #(.N_SRC(N)) uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_i(src_i),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_lvl(input int i, input logic [5:0] p, input logic f);
        wr(10'h100 + 10'(4*i), {24'd0, p, 1'b0, f});
        m_prio[i] = p; m_fast[i] = f;
    endtask

    // expected winner on a line: {valid, id, prio}
    function automatic logic [13:0] model(input logic fast);
        logic v = 1'b0; logic [6:0] id = 7'h7F; logic [5:0] p = 6'd0;
        for (int i = 0; i < N; i++) begin
            if (((src_i[i] | m_sw[i]) & ~m_mask[i]) && m_fast[i] == fast &&
                (m_prio[i] == 0 || {2'b0, m_prio[i]} < m_thr) &&
                (!v || m_prio[i] < p)) begin
                v = 1'b1; id = 7'(i); p = m_prio[i];
            end
        end
        return {v, id, p};
    endfunction

    task automatic check_line(input string tag, input logic fast);
        logic [13:0] e; logic [31:0] d;
        e = model(fast);
        rd(fast ? 10'h044 : 10'h040, d);
        chk({tag, " active"}, d, {25'd0, e[12:6]});
        rd(fast ? 10'h064 : 10'h060, d);
        chk({tag, " prio"}, d, {26'd0, e[5:0]});
        chk({tag, " line"}, {31'd0, fast ? fiq_o : irq_o}, {31'd0, e[13]});
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_prio[i] = '0; m_fast[i] = 1'b0; end
        m_mask = '1; m_sw = '0; m_thr = 8'hFF;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(10'h040, d); chk("R1 act irq", d, 32'h7F);
        rd(10'h044, d); chk("R1 act fiq", d, 32'h7F);
        rd(10'h060, d); chk("R1 prio irq", d, 32'h0);
        rd(10'h068, d); chk("R1 thresh", d, 32'hFF);
        rd(10'h0A4, d); chk("R1 mask bank1", d, 32'hFFFF_FFFF);
        chk("R1 lines", {30'd0, irq_o, fiq_o}, 32'd0);

        // R2 zero writes ignored, ones act
        wr(10'h088, 32'h0); rd(10'h084, d); chk("R2 zero unmask", d, 32'hFFFF_FFFF);
        wr(10'h088, 32'h0000_00F0); rd(10'h084, d); chk("R2 unmask", d, 32'hFFFF_FF0F);
        wr(10'h08C, 32'h0); rd(10'h084, d); chk("R2 zero mask", d, 32'hFFFF_FF0F);
        wr(10'h08C, 32'h0000_0030); rd(10'h084, d); chk("R2 mask", d, 32'hFFFF_FF3F);
        wr(10'h08C, 32'hFFFF_FFFF);

        // R4 config word readback
        set_lvl(5, 6'd10, 1'b0);
        rd(10'h114, d); chk("R4 lvl readback", d, 32'h28);

        // R8 idle line captures without acknowledge
        src_i[5] = 1'b1;
        wr(10'h088, 32'h20); m_mask[5] = 1'b0;
        rd(10'h040, d); chk("R8 idle capture", d, 32'd5);
        // R3 raw view shows only the input
        wr(10'h090, 32'h200); m_sw[9] = 1'b1;
        rd(10'h080, d); chk("R3 raw view", d, 32'h20);
        rd(10'h090, d); chk("R3 force readback", d, 32'h200);
        set_lvl(9, 6'd2, 1'b0);
        wr(10'h088, 32'h200); m_mask[9] = 1'b0;
        rd(10'h040, d); chk("R8 held winner", d, 32'd5);
        rd(10'h060, d); chk("R8 held prio", d, 32'd10);
        wr(10'h048, 32'h2);
        rd(10'h040, d); chk("R8 fast ack leaves normal", d, 32'd5);
        wr(10'h048, 32'h1);
        rd(10'h040, d); chk("R3 R5 forced winner", d, 32'd9);

        // R5 tie to lowest number
        set_lvl(3, 6'd2, 1'b0); src_i[3] = 1'b1;
        wr(10'h088, 32'h8); m_mask[3] = 1'b0;
        wr(10'h048, 32'h1);
        rd(10'h040, d); chk("R5 tie lowest", d, 32'd3);

        // R10 pending views
        rd(10'h098, d); chk("R10 pend normal", d, 32'h228);
        // R6 threshold masks prio >= thr
        wr(10'h068, 32'h2); m_thr = 8'h2;
        wr(10'h048, 32'h1);
        rd(10'h040, d); chk("R6 R7 none qualifies", d, 32'h7F);
        chk("R7 line low", {31'd0, irq_o}, 32'd0);
        rd(10'h098, d); chk("R10 view ignores thr", d, 32'h228);
        // R6 prio 0 passes threshold 0
        wr(10'h068, 32'h0); m_thr = 8'h0;
        set_lvl(40, 6'd0, 1'b0); src_i[40] = 1'b1;
        wr(10'h0A8, 32'h100); m_mask[40] = 1'b0;
        rd(10'h040, d); chk("R6 prio0 unmaskable", d, 32'd40);
        // R4 route to fast line
        set_lvl(7, 6'd1, 1'b1); src_i[7] = 1'b1;
        wr(10'h068, 32'hFF); m_thr = 8'hFF;
        wr(10'h088, 32'h80); m_mask[7] = 1'b0;
        rd(10'h044, d); chk("R4 fast route", d, 32'd7);
        rd(10'h09C, d); chk("R10 pend fast", d, 32'h80);
        // R3 forced clear
        wr(10'h094, 32'h200); m_sw[9] = 1'b0;
        rd(10'h090, d); chk("R3 force cleared", d, 32'h0);

        // R9 soft reset
        wr(10'h010, 32'h2);
        reg_addr = 10'h014; #1;
        chk("R9 busy", reg_rdata, 32'h0);
        rd(10'h014, d); chk("R9 done", d, 32'h1);
        model_reset();
        rd(10'h084, d); chk("R9 mask restored", d, 32'hFFFF_FFFF);
        rd(10'h040, d); chk("R9 act cleared", d, 32'h7F);

        // random rounds: R5 R6 R7 R8 R10
        for (int r = 0; r < 20; r++) begin
            logic [7:0] thr_pick [6];
            logic [31:0] e;
            thr_pick = '{8'h0, 8'h1, 8'h3, 8'h5, 8'h8, 8'hFF};
            src_i = {$urandom, $urandom};
            for (int i = 0; i < N; i++) set_lvl(i, 6'($urandom % 8), 1'($urandom));
            wr(10'h08C, 32'hFFFF_FFFF); wr(10'h0AC, 32'hFFFF_FFFF);
            m_mask = {$urandom, $urandom};
            wr(10'h088, ~m_mask[31:0]); wr(10'h0A8, ~m_mask[63:32]);
            wr(10'h094, 32'hFFFF_FFFF); wr(10'h0B4, 32'hFFFF_FFFF);
            m_sw = {$urandom & $urandom, $urandom & $urandom};
            wr(10'h090, m_sw[31:0]); wr(10'h0B0, m_sw[63:32]);
            m_thr = thr_pick[$urandom % 6];
            wr(10'h068, {24'd0, m_thr});
            wr(10'h048, 32'h3);
            check_line("R5 R6 R7 random normal", 1'b0);
            check_line("R5 R6 R7 random fast", 1'b1);
            e = '0;
            for (int i = 0; i < 32; i++) e[i] = (src_i[i] | m_sw[i]) & ~m_mask[i] & m_fast[i];
            rd(10'h09C, d); chk("R10 random pend fast", d, e);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule